// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a 32-bit processor whose instructions are word aligned and addressed by byte. Every cycle it examines the instruction word fetched from the current PC and the two register operands read for that instruction. From these it works out three candidate addresses. The first is the sequential address. The second is the PC-relative target of a conditional branch. The third is the region-absolute target of an unconditional jump. It then picks one candidate as the next PC and raises a flag whenever control flow leaves the sequential path.

The three candidates are brought out on separate ports next to the chosen address. This lets a surrounding design or a bench observe each one on its own. The PC register loads the chosen address on every rising clock edge. A synchronous active-low reset loads a parameterised start address instead. The unit has no pipelining, no delay slot, no exception handling and no register-indirect jump.

Top module: `npc_unit`

## Requirements
- R1: `seq_addr` always equals `pc` + 4, computed modulo 2^32, so the word at 0xFFFFFFFC is followed by address 0.
- R2: `br_target` equals `seq_addr` plus the sign-extended value of {instr[15:0], 2'b00}. The reach is -131072 to +131068 bytes from the instruction after the branch.
- R3: `jmp_target` equals {seq_addr[31:28], instr[25:0], 2'b00}. The region bits come from PC+4, not from the jump's own address.
- R4: For opcode instr[31:26] = 4 (branch if equal), `next_pc` is `br_target` and `taken` is 1 when `rs_val` equals `rt_val`. Otherwise `next_pc` is `seq_addr` and `taken` is 0.
- R5: For opcode 5 (branch if not equal), `next_pc` is `br_target` and `taken` is 1 when `rs_val` differs from `rt_val`. Otherwise `next_pc` is `seq_addr` and `taken` is 0.
- R6: For opcode 2 (jump), `next_pc` is `jmp_target` and `taken` is 1, whatever the operands are.
- R7: For any opcode other than 2, 4 or 5, `next_pc` is `seq_addr` and `taken` is 0. Operands and the low 26 instruction bits have no effect on these two outputs.
- R8: When `rst_n` is low at a rising edge, `pc` takes the value `RESET_VEC` (default 0x00400000) after that edge.
- R9: When `rst_n` is high at a rising edge, `pc` takes the value `next_pc` held before that edge.
- R10: Target arithmetic wraps modulo 2^32 and has no overflow indication. For example, a taken branch at PC 0 with offset field 0xFFFE goes to 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word fetched from `pc` |
| rs_val | input | 32 | Register operand selected by instr[25:21] |
| rt_val | input | 32 | Register operand selected by instr[20:16] |
| pc | output | 32 | Current program counter |
| seq_addr | output | 32 | Sequential address, PC+4 |
| br_target | output | 32 | Conditional-branch target |
| jmp_target | output | 32 | Absolute jump target |
| next_pc | output | 32 | Address to be loaded at the next edge |
| taken | output | 1 | High when `next_pc` is not the sequential address |

## Verification
The bound checker tests the decode rules on every cycle. Equal-compare and not-equal-compare branches must agree with the operand comparison. A jump is always taken, and unknown opcodes are never taken. Jump targets must keep the region bits of PC+4, and the PC must follow the chosen address or the reset vector from one edge to the next. The exact values of the arithmetic can only be shown by the bench's scenarios, which compare against an independent model. These scenarios cover the largest forward and backward offsets, wrapping below address 0 and past 0xFFFFFFFC, and a jump whose PC+4 crosses into a new 256 MB region.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared constants and types for the next-PC unit: instruction field
// widths, the opcodes that alter flow, and the flow-selection type.
// Assumes a fixed 32-bit instruction word with the opcode in the top six bits.
package npc_pkg;

    localparam int XLEN        = 32;
    localparam int OPC_W       = 6;
    localparam int IMM_W       = 16;
    localparam int JADDR_W     = 26;
    localparam int INSTR_BYTES = 4;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_JUMP   = 2'd2
    } flow_e;

endpackage

// File: rtl/npc_incr.sv
// Module npc_incr
// Adds a fixed step to an address. It is used for the sequential PC+4.
// Assumes modulo-2^W arithmetic; any carry out of the top bit is dropped.
module npc_incr #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic [W-1:0] addr_in,
    output logic [W-1:0] addr_out
);

    localparam logic [W-1:0] STEP_V = W'(STEP);

    // Wrapping increment by the instruction size.
    always_comb begin
        addr_out = addr_in + STEP_V;
    end

endmodule

// File: rtl/npc_br_target.sv
// Module npc_br_target
// Computes the PC-relative branch destination. The word offset gets two zero
// bits appended, is sign-extended to W bits and is added to the already
// incremented PC.
// Assumes W > IMM_W + 2; the sum wraps modulo 2^W.
module npc_br_target #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     base,
    input  logic [IMM_W-1:0] word_off,
    output logic [W-1:0]     target
);

    localparam int BYTE_OFF_W = IMM_W + 2;
    localparam int EXT_W      = W - BYTE_OFF_W;

    logic [BYTE_OFF_W-1:0] byte_off;
    logic [W-1:0]          off_ext;

    // Convert the word offset into a byte offset.
    always_comb begin
        byte_off = {word_off, 2'b00};
    end

    // Replicate the sign bit into the upper bits.
    always_comb begin
        off_ext = {{EXT_W{byte_off[BYTE_OFF_W-1]}}, byte_off};
    end

    // Add the offset to the incremented PC.
    always_comb begin
        target = base + off_ext;
    end

endmodule

// File: rtl/npc_jmp_target.sv
// Module npc_jmp_target
// Builds the absolute jump destination inside the current region. The region
// bits come from the incremented PC, the middle bits from the jump's address
// field, and two zero bits go at the bottom.
// Assumes W > JADDR_W + 2.
module npc_jmp_target #(
    parameter int W       = 32,
    parameter int JADDR_W = 26
) (
    input  logic [W-1:0]       base,
    input  logic [JADDR_W-1:0] jaddr,
    output logic [W-1:0]       target
);

    localparam int REGION_W = W - JADDR_W - 2;

    logic [REGION_W-1:0] region;

    // Take the region bits from the incremented PC.
    always_comb begin
        region = base[W-1 -: REGION_W];
    end

    // Concatenate region, word address and byte alignment.
    always_comb begin
        target = {region, jaddr, 2'b00};
    end

endmodule

// File: rtl/npc_flow_ctl.sv
// Module npc_flow_ctl
// Decodes the opcode and compares the operands to decide which candidate
// address is used. It also raises the taken flag.
// Assumes only the two compare branches and the jump change flow; every other
// opcode continues sequentially.
module npc_flow_ctl
    import npc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    output flow_e            sel,
    output logic             taken
);

    logic same;

    // Operand equality used by both compare branches.
    always_comb begin
        same = (op_a == op_b);
    end

    // Opcode decode into a flow choice.
    always_comb begin
        sel = FLOW_SEQ;
        case (opcode)
            OPC_BEQ:  sel = same  ? FLOW_BRANCH : FLOW_SEQ;
            OPC_BNE:  sel = !same ? FLOW_BRANCH : FLOW_SEQ;
            OPC_JUMP: sel = FLOW_JUMP;
            default:  sel = FLOW_SEQ;
        endcase
    end

    // Flag any departure from the sequential path.
    always_comb begin
        taken = (sel != FLOW_SEQ);
    end

endmodule

// File: rtl/npc_unit.sv
// Module npc_unit
// Top of the next-PC unit. It holds the PC register, forms the sequential,
// branch and jump candidates, and selects the next PC. The next PC is loaded
// on every rising edge.
// Assumes a synchronous active-low reset and a word-aligned RESET_VEC.
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc,
    output logic [31:0] seq_addr,
    output logic [31:0] br_target,
    output logic [31:0] jmp_target,
    output logic [31:0] next_pc,
    output logic        taken
);

    logic [OPC_W-1:0]   opcode;
    logic [IMM_W-1:0]   word_off;
    logic [JADDR_W-1:0] jaddr;
    flow_e              sel;
    logic               ctl_taken;

    // Split the instruction word into its fields.
    always_comb begin
        opcode   = instr[XLEN-1 -: OPC_W];
        word_off = instr[IMM_W-1:0];
        jaddr    = instr[JADDR_W-1:0];
    end

    npc_incr #(
        .W    (XLEN),
        .STEP (INSTR_BYTES)
    ) u_incr (
        .addr_in  (pc),
        .addr_out (seq_addr)
    );

    npc_br_target #(
        .W     (XLEN),
        .IMM_W (IMM_W)
    ) u_br (
        .base     (seq_addr),
        .word_off (word_off),
        .target   (br_target)
    );

    npc_jmp_target #(
        .W       (XLEN),
        .JADDR_W (JADDR_W)
    ) u_jmp (
        .base   (seq_addr),
        .jaddr  (jaddr),
        .target (jmp_target)
    );

    npc_flow_ctl #(
        .W (XLEN)
    ) u_ctl (
        .opcode (opcode),
        .op_a   (rs_val),
        .op_b   (rt_val),
        .sel    (sel),
        .taken  (ctl_taken)
    );

    // Pick the candidate named by the flow decision.
    always_comb begin
        case (sel)
            FLOW_BRANCH: next_pc = br_target;
            FLOW_JUMP:   next_pc = jmp_target;
            default:     next_pc = seq_addr;
        endcase
        taken = ctl_taken;
    end

    // PC register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_VEC;
        end else begin
            pc <= next_pc;
        end
    end

endmodule

// File: rtl/npc_unit_chk.sv
// Module npc_unit_chk
// Checker bound to npc_unit. It tests the decode rules, the region of jump
// targets and the PC update across edges.
// Assumes it sees only the top-level ports of npc_unit.
module npc_unit_chk #(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] pc,
    input logic [31:0] seq_addr,
    input logic [31:0] br_target,
    input logic [31:0] jmp_target,
    input logic [31:0] next_pc,
    input logic        taken
);

    logic [5:0] op;
    logic       is_flow_op;

    // Opcode view for the properties.
    always_comb begin
        op         = instr[31:26];
        is_flow_op = (op == 6'd2) || (op == 6'd4) || (op == 6'd5);
    end

    assert_seq_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> pc == $past(pc) + 32'd4);

    assert_br_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        br_target[1:0] == seq_addr[1:0]);

    assert_jmp_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_target[31:28] == seq_addr[31:28] && jmp_target[1:0] == 2'b00);

    assert_beq_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op == 6'd4 |-> (taken == (rs_val == rt_val)) &&
                       (next_pc == (taken ? br_target : seq_addr)));

    assert_bne_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op == 6'd5 |-> (taken == (rs_val != rt_val)) &&
                       (next_pc == (taken ? br_target : seq_addr)));

    assert_jump_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op == 6'd2 |-> taken && next_pc == jmp_target);

    assert_other_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_flow_op |-> !taken && next_pc == seq_addr);

    assert_reset_vec_R8: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_VEC);

    assert_pc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc == $past(next_pc));

endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr      (instr),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .pc         (pc),
    .seq_addr   (seq_addr),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .next_pc    (next_pc),
    .taken      (taken)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
// Bench for npc_unit. A behavioural model of the PC is compared with every
// output of the design on every clock.
module npc_unit_tb;

    localparam logic [31:0] RV = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc, seq_addr, br_target, jmp_target, next_pc;
    logic        taken;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [31:0] m_pc;
    bit          m_valid = 0;
    bit          m_after_rst = 0;

    always #2 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr      (instr),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .pc         (pc),
        .seq_addr   (seq_addr),
        .br_target  (br_target),
        .jmp_target (jmp_target),
        .next_pc    (next_pc),
        .taken      (taken)
    );

    function automatic logic [31:0] enc_i(input int op, input int imm);
        enc_i = {op[5:0], 5'd16, 5'd17, imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(input int op, input int addr);
        enc_j = {op[5:0], addr[25:0]};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, then advance the model.
    task automatic step(input logic rn, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
        longint      off;
        logic [31:0] e_seq, e_br, e_jmp, e_next;
        logic        e_tk;
        int          op;
        string       tag;
        @(negedge clk);
        rst_n  = rn;
        instr  = ins;
        rs_val = a;
        rt_val = b;
        #1;
        e_next = '0;
        if (m_valid) begin
            op    = int'(ins[31:26]);
            e_seq = m_pc + 32'd4;
            off   = longint'($signed(ins[15:0])) * 4;
            e_br  = 32'(longint'(e_seq) + off);
            e_jmp = (e_seq & 32'hF000_0000) | ({6'd0, ins[25:0]} << 2);
            if (op == 4) begin
                tag = "R4"; e_tk = (a == b);
            end else if (op == 5) begin
                tag = "R5"; e_tk = (a != b);
            end else if (op == 2) begin
                tag = "R6"; e_tk = 1'b1;
            end else begin
                tag = "R7"; e_tk = 1'b0;
            end
            e_next = !e_tk ? e_seq : (op == 2 ? e_jmp : e_br);
            chk(m_after_rst ? "R8" : "R9", "pc", pc, m_pc);
            chk("R1", "seq_addr", seq_addr, e_seq);
            chk("R2/R10", "br_target", br_target, e_br);
            chk("R3", "jmp_target", jmp_target, e_jmp);
            chk(tag, "next_pc", next_pc, e_next);
            chk(tag, "taken", {31'd0, taken}, {31'd0, e_tk});
        end
        @(posedge clk);
        if (!rn) begin
            m_pc = RV; m_valid = 1; m_after_rst = 1;
        end else if (m_valid) begin
            m_pc = e_next; m_after_rst = 0;
        end
    endtask

    initial begin
        step(1'b0, '0, '0, '0);
        step(1'b0, '0, '0, '0);                  // R8 checked next cycle
        for (int i = 0; i < 8; i++) step(1'b1, '0, i, i);   // R7 nops to 0x00400020
        step(1'b1, enc_i(5, 2), 32'd1, 32'd2);   // R5 taken -> 0x0040002C
        step(1'b1, enc_i(5, 9), 32'd7, 32'd7);   // R5 not taken
        step(1'b1, enc_i(4, 16'hFFFD), 32'd3, 32'd3); // R4 backward
        step(1'b1, enc_i(4, 40), 32'd3, 32'd4);  // R4 not taken
        step(1'b1, enc_i(6'h23, 16'h8000), 32'd5, 32'd5); // R7 ignored
        step(1'b1, enc_j(6, 26'h3FF_FFFF), 32'd1, 32'd9); // R7 ignored
        step(1'b1, enc_j(3, 26'h123_4567), 32'd0, 32'd0); // R7 ignored
        step(1'b1, enc_i(4, 16'h7FFF), 32'd8, 32'd8);  // R2 max forward
        step(1'b1, enc_i(5, 16'h8000), 32'd8, 32'd1);  // R2 max backward
        step(1'b1, enc_j(2, 0), 32'd1, 32'd2);         // R6 -> region base 0
        step(1'b1, enc_i(4, 16'hFFFE), 32'd0, 32'd0);  // R10 wrap to 0xFFFFFFFC
        step(1'b1, '0, '0, '0);                        // R1 wrap to 0
        step(1'b1, enc_j(2, 26'h3FF_FFFF), 32'd4, 32'd4); // R6 -> 0x0FFFFFFC
        step(1'b1, enc_j(2, 0), 32'd0, 32'd0);         // R3 region from PC+4
        step(1'b1, enc_i(5, 16'hFFFF), 32'd1, 32'd0);  // R5 from new region
        step(1'b0, enc_j(2, 5), 32'd0, 32'd0);         // R8 reset mid-run
        step(1'b1, '0, '0, '0);
        for (int i = 0; i < 400; i++) begin
            int          sel;
            logic [31:0] ins, a, b;
            sel = $urandom_range(0, 4);
            ins = $urandom;
            case (sel)
                0: ins[31:26] = 6'd2;
                1: ins[31:26] = 6'd4;
                2: ins[31:26] = 6'd5;
                default: ;
            endcase
            a = $urandom_range(0, 3);
            b = $urandom_range(0, 3);
            step(1'b1, ins, a, b);
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule